// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block remembers the byte footprints of the stores that have issued in the current instruction group. When a load from the same group is presented, it reports at once whether that load touches any of those footprints. Each footprint has three parts: a base tag that names the pointer the access goes through, a signed byte offset from that base, and a byte count. Address generation and the memory access itself happen outside the block.

Stores are recorded on the clock edge. The load check is purely combinational from the recorded state, so the overlap flag follows the load inputs in the same cycle. The store and load strobes are plain qualifiers. The block accepts every strobe in every cycle, so it applies no back-pressure and has no ready signal. Asserting the group-clear input starts a new group.

Top module: `sld_overlap_top`

## Requirements
- R1: After reset the block holds no records, and `hit_o` is 0 for any load.
- R2: A store with `st_size_known_i`=1 is recorded in the cycle after its strobe. Only four records are held (parameter NUM_REC=4), and any store that arrives while four are held is dropped.
- R3: A store with `st_size_known_i`=0 is not recorded and does not consume a record.
- R4: A load whose base and offset both equal a record's base and offset hits, whatever the two sizes are, including size 0.
- R5: With equal bases and the record's offset below the load's offset, the load hits exactly when record offset plus record size is greater than the load offset.
- R6: With equal bases and the record's offset above the load's offset, the load hits exactly when load offset plus load size is greater than the record offset.
- R7: A record whose base differs from the load's base never produces a hit.
- R8: `hit_o` is 1 only while `ld_valid_i`=1, `ld_size_known_i`=1 and at least one record is held.
- R9: `grp_clear_i` empties all records from the next cycle on. A store strobe in the same cycle as a clear is dropped.
- R10: A load checked in the same cycle as a store strobe is compared only against the records that existed before that cycle.
- R11: Offsets are 16-bit two's complement and sizes are 4-bit unsigned. The interval sums use one extra bit, so offsets near +32767 and -32768 do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grp_clear_i | input | 1 | Start a new group and drop all records |
| st_valid_i | input | 1 | Store strobe |
| st_size_known_i | input | 1 | Store byte count is known |
| st_base_i | input | 8 | Store base tag |
| st_off_i | input | 16 | Store signed byte offset |
| st_size_i | input | 4 | Store byte count |
| ld_valid_i | input | 1 | Load check strobe |
| ld_size_known_i | input | 1 | Load byte count is known |
| ld_base_i | input | 8 | Load base tag |
| ld_off_i | input | 16 | Load signed byte offset |
| ld_size_i | input | 4 | Load byte count |
| hit_o | output | 1 | Load overlaps a recorded store |

## Verification
A wrong record count or a corrupted entry has no status pin of its own, so it can only show up through `hit_o`. It shows up as a missed hit on a load aimed at a store that should be held, or as a spurious hit on a load aimed at a dropped or cleared store. Because the flag is combinational, the error is visible in the first cycle after the faulty write, on the first load that probes the affected footprint. The bench therefore probes every store slot, the store that is dropped when the bank is full, and the state just after a clear. It sweeps offsets and sizes around a single record so that every interval boundary is probed.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int DEF_NUM_REC = 4;
  localparam int DEF_BASE_W  = 8;
  localparam int DEF_OFF_W   = 16;
  localparam int DEF_SIZE_W  = 4;
endpackage

// File: rtl/sld_record_bank.sv
module sld_record_bank
  import sld_pkg::*;
#(
  parameter int NUM_REC = DEF_NUM_REC,
  parameter int BASE_W  = DEF_BASE_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int SIZE_W  = DEF_SIZE_W,
  localparam int CNT_W  = $clog2(NUM_REC + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_i,
  input  logic                             wr_i,
  input  logic                             wr_known_i,
  input  logic [BASE_W-1:0]                wr_base_i,
  input  logic [OFF_W-1:0]                 wr_off_i,
  input  logic [SIZE_W-1:0]                wr_size_i,
  output logic [NUM_REC-1:0]               live_o,
  output logic [NUM_REC-1:0][BASE_W-1:0]   base_o,
  output logic [NUM_REC-1:0][OFF_W-1:0]    off_o,
  output logic [NUM_REC-1:0][SIZE_W-1:0]   size_o,
  output logic [CNT_W-1:0]                 cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_REC);

  logic [CNT_W-1:0] cnt_q;
  logic             take;

  // A record slot is consumed only by a sized store while room remains and no clear is pending.
  assign take = wr_i && wr_known_i && !clear_i && (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (take)     cnt_q <= cnt_q + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REC; gi++) begin : g_slot
      logic [BASE_W-1:0] base_q;
      logic [OFF_W-1:0]  off_q;
      logic [SIZE_W-1:0] size_q;
      logic              sel;
      assign sel = take && (cnt_q == CNT_W'(gi));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q <= '0;
          off_q  <= '0;
          size_q <= '0;
        end else if (sel) begin
          base_q <= wr_base_i;
          off_q  <= wr_off_i;
          size_q <= wr_size_i;
        end
      end
      assign live_o[gi] = CNT_W'(gi) < cnt_q;
      assign base_o[gi] = base_q;
      assign off_o[gi]  = off_q;
      assign size_o[gi] = size_q;
    end
  endgenerate

  assign cnt_o = cnt_q;

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  assert_full_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL && !clear_i) |=> cnt_q == FULL);
  assert_unknown_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_known_i && !clear_i) |=> $stable(cnt_q));
  assert_clear_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  assert_one_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && wr_i && wr_known_i && cnt_q != FULL) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/sld_interval_cmp.sv
module sld_interval_cmp
  import sld_pkg::*;
#(
  parameter int BASE_W = DEF_BASE_W,
  parameter int OFF_W  = DEF_OFF_W,
  parameter int SIZE_W = DEF_SIZE_W,
  localparam int EXT_W = OFF_W + 1
) (
  input  logic              live_i,
  input  logic [BASE_W-1:0] s_base_i,
  input  logic [OFF_W-1:0]  s_off_i,
  input  logic [SIZE_W-1:0] s_size_i,
  input  logic [BASE_W-1:0] l_base_i,
  input  logic [OFF_W-1:0]  l_off_i,
  input  logic [SIZE_W-1:0] l_size_i,
  output logic              match_o
);
  logic signed [EXT_W-1:0] s_ext, l_ext, s_end, l_end, s_len, l_len;
  logic                    same_base, same_off, s_below;

  always_comb begin
    s_ext = $signed({s_off_i[OFF_W-1], s_off_i});
    l_ext = $signed({l_off_i[OFF_W-1], l_off_i});
    s_len = $signed({{(EXT_W-SIZE_W){1'b0}}, s_size_i});
    l_len = $signed({{(EXT_W-SIZE_W){1'b0}}, l_size_i});
    s_end = s_ext + s_len;
    l_end = l_ext + l_len;
    same_base = (s_base_i == l_base_i);
    same_off  = (s_ext == l_ext);
    s_below   = (s_ext < l_ext);
    match_o = 1'b0;
    if (live_i && same_base) begin
      if (same_off)      match_o = 1'b1;
      else if (s_below)  match_o = (s_end > l_ext);
      else               match_o = (l_end > s_ext);
    end
  end
endmodule

// File: rtl/sld_overlap_top.sv
module sld_overlap_top
  import sld_pkg::*;
#(
  parameter int NUM_REC = DEF_NUM_REC,
  parameter int BASE_W  = DEF_BASE_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int SIZE_W  = DEF_SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_clear_i,
  input  logic              st_valid_i,
  input  logic              st_size_known_i,
  input  logic [BASE_W-1:0] st_base_i,
  input  logic [OFF_W-1:0]  st_off_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              ld_valid_i,
  input  logic              ld_size_known_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [OFF_W-1:0]  ld_off_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              hit_o
);
  localparam int CNT_W = $clog2(NUM_REC + 1);

  logic [NUM_REC-1:0]             live;
  logic [NUM_REC-1:0][BASE_W-1:0] r_base;
  logic [NUM_REC-1:0][OFF_W-1:0]  r_off;
  logic [NUM_REC-1:0][SIZE_W-1:0] r_size;
  logic [CNT_W-1:0]               cnt;
  logic [NUM_REC-1:0]             match;

  sld_record_bank #(
    .NUM_REC(NUM_REC), .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (grp_clear_i),
    .wr_i       (st_valid_i),
    .wr_known_i (st_size_known_i),
    .wr_base_i  (st_base_i),
    .wr_off_i   (st_off_i),
    .wr_size_i  (st_size_i),
    .live_o     (live),
    .base_o     (r_base),
    .off_o      (r_off),
    .size_o     (r_size),
    .cnt_o      (cnt)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REC; gi++) begin : g_cmp
      sld_interval_cmp #(
        .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
      ) u_cmp (
        .live_i   (live[gi]),
        .s_base_i (r_base[gi]),
        .s_off_i  (r_off[gi]),
        .s_size_i (r_size[gi]),
        .l_base_i (ld_base_i),
        .l_off_i  (ld_off_i),
        .l_size_i (ld_size_i),
        .match_o  (match[gi])
      );

      assert_other_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_base[gi] != ld_base_i) |-> !match[gi]);
      assert_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live[gi] && r_base[gi] == ld_base_i && r_off[gi] == ld_off_i) |-> match[gi]);
    end
  endgenerate

  // The check runs only for a sized load while the group holds at least one store.
  assign hit_o = ld_valid_i && ld_size_known_i && (cnt != '0) && (|match);

  assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ld_valid_i && ld_size_known_i && cnt != '0));
  assert_live_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(live) == int'(cnt));
endmodule

// File: tb/test_sld_overlap_top.sv
module test_sld_overlap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        st_v = 1'b0, st_k = 1'b0;
  logic [7:0]  st_b = '0;
  logic [15:0] st_o = '0;
  logic [3:0]  st_s = '0;
  logic        ld_v = 1'b0, ld_k = 1'b0;
  logic [7:0]  ld_b = '0;
  logic [15:0] ld_o = '0;
  logic [3:0]  ld_s = '0;
  logic        hit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sld_overlap_top i_sld_overlap_top (
    .clk_i(clk), .rst_ni(rst_n), .grp_clear_i(clr),
    .st_valid_i(st_v), .st_size_known_i(st_k), .st_base_i(st_b),
    .st_off_i(st_o), .st_size_i(st_s),
    .ld_valid_i(ld_v), .ld_size_known_i(ld_k), .ld_base_i(ld_b),
    .ld_off_i(ld_o), .ld_size_i(ld_s), .hit_o(hit)
  );

  function automatic bit ref_ovl(int so, int ss, int lo, int ls);
    if (so == lo) return 1'b1;
    if (so < lo)  return (so + ss) > lo;
    return (lo + ls) > so;
  endfunction

  task automatic chk(string req, bit exp);
    checks++;
    if (hit !== exp) begin
      fails++;
      $display("FAIL %s: hit=%b expected=%b (load base=%0d off=%0d size=%0d)",
               req, hit, exp, ld_b, $signed(ld_o), ld_s);
    end
  endtask

  task automatic store(int b, int o, int s, bit known);
    @(negedge clk);
    st_v = 1'b1; st_k = known; st_b = 8'(b); st_o = 16'(o); st_s = 4'(s);
    @(negedge clk);
    st_v = 1'b0;
  endtask

  task automatic clear_grp();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic probe(string req, int b, int o, int s, bit exp);
    ld_v = 1'b1; ld_k = 1'b1; ld_b = 8'(b); ld_o = 16'(o); ld_s = 4'(s);
    #1 chk(req, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    probe("R1", 0, 0, 15, 1'b0);

    // R5 R6 R4 R11: sweep around one record at offset 0
    for (int ss = 0; ss < 16; ss++) begin
      clear_grp();
      store(3, 0, ss, 1'b1);
      for (int lo = -18; lo <= 18; lo++)
        for (int ls = 0; ls < 16; ls++)
          probe(lo == 0 ? "R4" : (lo > 0 ? "R5" : "R6"), 3, lo, ls, ref_ovl(0, ss, lo, ls));
      probe("R7", 4, 0, 15, 1'b0);
    end

    // R11: offsets at the signed extremes
    clear_grp();
    store(5, 32767, 15, 1'b1);
    store(6, -32768, 15, 1'b1);
    for (int ls = 0; ls < 16; ls++) begin
      probe("R11", 5, -32768, ls, 1'b0);
      probe("R11", 5, 32760, ls, ref_ovl(32767, 15, 32760, ls));
      probe("R11", 6, 32767, ls, 1'b0);
      probe("R11", 6, -32760, ls, ref_ovl(-32768, 15, -32760, ls));
    end

    // R8: gating by load strobe and known size
    ld_b = 8'd5; ld_o = 16'd32767; ld_s = 4'd1;
    ld_v = 1'b0; ld_k = 1'b1; #1 chk("R8", 1'b0);
    ld_v = 1'b1; ld_k = 1'b0; #1 chk("R8", 1'b0);

    // R2: four slots, fifth dropped
    clear_grp();
    for (int i = 0; i < 5; i++) store(1, i * 10, 4, 1'b1);
    for (int i = 0; i < 4; i++) probe("R2", 1, i * 10 + 2, 1, 1'b1);
    probe("R2", 1, 40, 4, 1'b0);

    // R3: unknown-size store skipped, slot still free
    clear_grp();
    store(2, 100, 8, 1'b0);
    probe("R3", 2, 100, 8, 1'b0);
    store(2, 200, 8, 1'b1);
    for (int i = 0; i < 3; i++) store(9, i * 50, 1, 1'b1);
    probe("R3", 2, 204, 1, 1'b1);
    probe("R3", 9, 100, 1, 1'b1);

    // R9: clear empties; clear wins over simultaneous store
    clear_grp();
    probe("R9", 9, 0, 1, 1'b0);
    @(negedge clk);
    clr = 1'b1; st_v = 1'b1; st_k = 1'b1; st_b = 8'd7; st_o = 16'd0; st_s = 4'd4;
    @(negedge clk);
    clr = 1'b0; st_v = 1'b0;
    probe("R9", 7, 0, 4, 1'b0);

    // R10: same-cycle store is not seen by the check
    @(negedge clk);
    st_v = 1'b1; st_k = 1'b1; st_b = 8'd7; st_o = 16'd16; st_s = 4'd4;
    probe("R10", 7, 16, 4, 1'b0);
    @(negedge clk);
    st_v = 1'b0;
    probe("R10", 7, 16, 4, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule